// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Per-Pin Interrupt Sensing

This block is a memory-mapped general-purpose I/O peripheral for a parameterised number of pins (16 by default). Software reaches it over a plain 32-bit register bus made of an address, a write strobe, write data and read data. Writes take effect on the rising clock edge where the strobe is high. Read data is a combinational function of the address. The bus has no valid/ready handshake and no back-pressure: every access completes in one cycle.

Each pin has three controls. A direction bit enables its output driver. An output-data bit gives the driven level and also selects the interrupt polarity. A mode bit switches the pin to detection on both edges. Pin inputs pass through a two-flop synchroniser, and the synchronised levels serve both the readback and the interrupt sensing.

A build parameter picks one of two interrupt styles. In the edge style, every qualifying edge sets a sticky pending bit, and software clears it by writing 1 to a status register. In the level style, each interrupt line follows the polarity-corrected level directly. Each pin drives its own active-high interrupt line to an external interrupt controller.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the direction, output-data, mode and pending registers all read 0, pin_oe is all 0 and irq is all 0.
- R2: A write to offset 0x00 loads the direction register. pin_oe equals that register from the next cycle on, and pin_out always carries the output-data register.
- R3: A write to offset 0x10 loads the output-data register. Reading 0x10 returns it, and bits above the pin count always read 0.
- R4: A write to offset 0x18 sets every output-data bit written as 1 and leaves the bits written as 0 unchanged. Reading 0x18 returns 0.
- R5: A write to offset 0x20 clears every output-data bit written as 1 and leaves the bits written as 0 unchanged. Reading 0x20 returns 0.
- R6: Reading offset 0x08 returns the pin levels after a two-flop synchroniser, so a change is visible two clock edges later. Writes to 0x08 have no effect.
- R7: With mode bit 0 and output-data bit 0 (offset 0x30 holds the mode bits), a rising edge on the pin raises its interrupt and a falling edge does not.
- R8: With mode bit 0 and output-data bit 1, a falling edge raises the interrupt and a rising edge does not.
- R9: With mode bit 1, both rising and falling edges raise the interrupt, whatever the output-data bit holds.
- R10: In the edge style, irq shows sticky pending bits, which can be read at offset 0x38. Writing 1 to a bit at 0x38 clears that bit, and writing 0 leaves it unchanged. An edge sets its pending bit three clock edges after the pin changes.
- R11: When an edge and a clear write hit the same pending bit in the same cycle, the bit stays set.
- R12: In the level style, a pin with mode bit 0 gives irq = synchronised level XOR output-data bit. A pin with mode bit 1 gives a one-cycle pulse for each edge.
- R13: Reads of unmapped offsets return 0 and writes to them change nothing. This covers 0x38 in the level style.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Combinational read data for bus_addr |
| pin_in | input | NPINS (16) | Raw pin levels |
| pin_out | output | NPINS (16) | Driven pin levels (output-data register) |
| pin_oe | output | NPINS (16) | Output enables (direction register) |
| irq | output | NPINS (16) | Active-high interrupt line per pin |

## Verification
The hardest case to reach is the collision between a pending-clear write and a fresh edge on the same pin. The bench reaches it by counting synchroniser stages exactly. It changes the pin at a falling clock edge and then asserts the clear strobe at the falling edge two cycles later, so that both land on the same rising edge. The one-cycle pulse of a both-edge pin in the level style is just as narrow. The bench samples it in the one half-cycle where it is high, then checks that it has gone one cycle later. A second instance built in the level style shares the bus and pins with the edge-style instance, so both styles see the same stimulus.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [7:0] OFS_DIR  = 8'h00;
  localparam logic [7:0] OFS_IN   = 8'h08;
  localparam logic [7:0] OFS_OUT  = 8'h10;
  localparam logic [7:0] OFS_SET  = 8'h18;
  localparam logic [7:0] OFS_CLR  = 8'h20;
  localparam logic [7:0] OFS_MODE = 8'h30;
  localparam logic [7:0] OFS_PEND = 8'h38;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIR, SEL_IN, SEL_OUT, SEL_SET, SEL_CLR, SEL_MODE, SEL_PEND
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign prev = hist_q;
endmodule

// File: rtl/gpio_sense.sv
module gpio_sense #(
  parameter int W = 16
) (
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] odata,
  input  logic [W-1:0] imode,
  output logic [W-1:0] evt,
  output logic [W-1:0] act
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic rise, fall;
    assign rise   = lvl[g] & ~prev[g];
    assign fall   = ~lvl[g] & prev[g];
    assign evt[g] = imode[g] ? (rise | fall) : (odata[g] ? fall : rise);
    assign act[g] = lvl[g] ^ odata[g];
  end
endmodule

// File: rtl/gpio_pend.sv
module gpio_pend #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend
);
  logic [W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend = pend_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W        = 16,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter bit EDGE_IRQ = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [W-1:0]  pin_lvl,
  input  logic [W-1:0]  pend,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  odata_q,
  output logic [W-1:0]  imode_q,
  output logic [W-1:0]  pend_clr
);
  reg_sel_e     sel;
  logic [W-1:0] wbits;
  logic         unused_wdata;

  assign wbits        = bus_wdata[W-1:0];
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == AW'(OFS_DIR))              sel = SEL_DIR;
    else if (bus_addr == AW'(OFS_IN))               sel = SEL_IN;
    else if (bus_addr == AW'(OFS_OUT))              sel = SEL_OUT;
    else if (bus_addr == AW'(OFS_SET))              sel = SEL_SET;
    else if (bus_addr == AW'(OFS_CLR))              sel = SEL_CLR;
    else if (bus_addr == AW'(OFS_MODE))             sel = SEL_MODE;
    else if (EDGE_IRQ && bus_addr == AW'(OFS_PEND)) sel = SEL_PEND;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      odata_q <= '0;
      imode_q <= '0;
    end else if (bus_we) begin
      case (sel)
        SEL_DIR:  dir_q   <= wbits;
        SEL_OUT:  odata_q <= wbits;
        SEL_SET:  odata_q <= odata_q | wbits;
        SEL_CLR:  odata_q <= odata_q & ~wbits;
        SEL_MODE: imode_q <= wbits;
        default:  ;
      endcase
    end
  end

  assign pend_clr = (bus_we && sel == SEL_PEND) ? wbits : '0;

  always_comb begin
    case (sel)
      SEL_DIR:  bus_rdata = DW'(dir_q);
      SEL_IN:   bus_rdata = DW'(pin_lvl);
      SEL_OUT:  bus_rdata = DW'(odata_q);
      SEL_MODE: bus_rdata = DW'(imode_q);
      SEL_PEND: bus_rdata = DW'(pend);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS    = 16,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter bit EDGE_IRQ = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] irq
);
  logic [NPINS-1:0] lvl, prev, dir_q, odata_q, imode_q, pend_clr, pend, evt;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .lvl(lvl), .prev(prev)
  );

  gpio_regs #(.W(NPINS), .DW(DW), .AW(AW), .EDGE_IRQ(EDGE_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_lvl(lvl), .pend(pend),
    .dir_q(dir_q), .odata_q(odata_q), .imode_q(imode_q), .pend_clr(pend_clr)
  );

  if (EDGE_IRQ) begin : g_edge
    logic [NPINS-1:0] act_unused;
    gpio_sense #(.W(NPINS)) u_sense (
      .lvl(lvl), .prev(prev), .odata(odata_q), .imode(imode_q),
      .evt(evt), .act(act_unused)
    );
    gpio_pend #(.W(NPINS)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_i(evt), .clr_i(pend_clr), .pend(pend)
    );
    assign irq = pend;
  end else begin : g_level
    logic [NPINS-1:0] act;
    logic [NPINS-1:0] clr_unused;
    gpio_sense #(.W(NPINS)) u_sense (
      .lvl(lvl), .prev(prev), .odata(odata_q), .imode(imode_q),
      .evt(evt), .act(act)
    );
    assign clr_unused = pend_clr;
    assign pend       = '0;
    for (genvar g = 0; g < NPINS; g++) begin : g_sel
      assign irq[g] = imode_q[g] ? evt[g] : act[g];
    end
  end

  assign pin_out = odata_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NPINS    = 16,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter bit EDGE_IRQ = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] irq
);
  logic mapped, rd_value_reg;
  assign rd_value_reg = bus_addr == AW'(OFS_DIR) || bus_addr == AW'(OFS_IN) ||
                        bus_addr == AW'(OFS_OUT) || bus_addr == AW'(OFS_MODE) ||
                        (EDGE_IRQ && bus_addr == AW'(OFS_PEND));
  assign mapped = rd_value_reg;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (irq == '0 && pin_oe == '0));

  assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_DIR)) |=> pin_oe == $past(bus_wdata[NPINS-1:0]));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NPINS] == '0);

  assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_SET)) |=>
      (pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]));

  assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_CLR)) |=>
      (pin_out & $past(bus_wdata[NPINS-1:0])) == '0);

  assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == '0);

  if (EDGE_IRQ) begin : g_edge_chk
    assert_pending_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == AW'(OFS_PEND)) |=> (irq & $past(irq)) == $past(irq));
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NPINS(NPINS), .DW(DW), .AW(AW), .EDGE_IRQ(EDGE_IRQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq(irq)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_lvl;
  logic [N-1:0] pins = '0;
  logic [N-1:0] pout, poe, irq, pout_l, poe_l, irq_l;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.EDGE_IRQ(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pins), .pin_out(pout), .pin_oe(poe), .irq(irq)
  );

  gpio_irq_ctrl #(.EDGE_IRQ(1'b0)) dut_lvl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata_lvl), .pin_in(pins), .pin_out(pout_l), .pin_oe(poe_l), .irq(irq_l)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'h0000_A5A5, 32'h0, 4'd2},
    '{1'b0, 8'h00, 32'h0,         32'h0000_A5A5, 4'd2},  // R2
    '{1'b1, 8'h10, 32'hFFFF_1234, 32'h0, 4'd3},
    '{1'b0, 8'h10, 32'h0,         32'h0000_1234, 4'd3},  // R3 upper bits dropped
    '{1'b1, 8'h18, 32'h0000_00F0, 32'h0, 4'd4},
    '{1'b0, 8'h10, 32'h0,         32'h0000_12F4, 4'd4},  // R4
    '{1'b1, 8'h20, 32'h0000_1004, 32'h0, 4'd5},
    '{1'b0, 8'h10, 32'h0,         32'h0000_02F0, 4'd5},  // R5
    '{1'b1, 8'h18, 32'h0,         32'h0, 4'd4},
    '{1'b0, 8'h10, 32'h0,         32'h0000_02F0, 4'd4},  // R4 zeros keep
    '{1'b1, 8'h20, 32'h0,         32'h0, 4'd5},
    '{1'b0, 8'h10, 32'h0,         32'h0000_02F0, 4'd5},  // R5 zeros keep
    '{1'b0, 8'h18, 32'h0,         32'h0, 4'd4},          // R4 alias reads 0
    '{1'b0, 8'h20, 32'h0,         32'h0, 4'd5},          // R5 alias reads 0
    '{1'b1, 8'h30, 32'h0000_00FF, 32'h0, 4'd9},
    '{1'b0, 8'h30, 32'h0,         32'h0000_00FF, 4'd9},  // R9 mode readback
    '{1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0, 4'd13},
    '{1'b0, 8'h04, 32'h0,         32'h0, 4'd13},         // R13
    '{1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0, 4'd13},
    '{1'b0, 8'h00, 32'h0,         32'h0000_A5A5, 4'd13}, // R13 no side effect
    '{1'b1, 8'h08, 32'h0000_FFFF, 32'h0, 4'd6},
    '{1'b0, 8'h08, 32'h0,         32'h0, 4'd6}           // R6 write ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic drive_pins(input logic [N-1:0] v, input int wait_n);
    @(negedge clk);
    pins = v;
    repeat (wait_n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 pin_oe", 32'(poe), 32'h0);
    bus_read(8'h00, 32'h0, "R1 dir");
    bus_read(8'h10, 32'h0, "R1 out");
    bus_read(8'h30, 32'h0, "R1 mode");
    bus_read(8'h38, 32'h0, "R1 pend");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].a, VEC[i].d);
      else bus_read(VEC[i].a, VEC[i].exp, $sformatf("R%0d vec%0d", VEC[i].req, i));
    end

    // R2 pins follow registers
    chk("R2 pin_oe", 32'(poe), 32'h0000_A5A5);
    chk("R2 pin_out", 32'(pout), 32'h0000_02F0);

    bus_write(8'h30, 32'h0);
    bus_write(8'h10, 32'h0);
    bus_write(8'h38, 32'hFFFF);
    chk("R10 clean start", 32'(irq), 32'h0);

    // R7 rising sense, R6 readback, R12 level high
    drive_pins(16'h0001, 3);
    chk("R7 rise sets", 32'(irq), 32'h0001);
    chk("R12 level high", 32'(irq_l), 32'h0001);
    bus_read(8'h08, 32'h0000_0001, "R6 input readback");
    drive_pins(16'h0000, 3);
    chk("R10 sticky after fall", 32'(irq), 32'h0001);
    chk("R12 level drops", 32'(irq_l), 32'h0);
    bus_write(8'h38, 32'h0001);
    chk("R10 clear", 32'(irq), 32'h0);

    // R7 falling edge ignored
    drive_pins(16'h0008, 3);
    bus_write(8'h38, 32'h0008);
    drive_pins(16'h0000, 3);
    chk("R7 fall ignored", 32'(irq), 32'h0);

    // R8 inverted sense
    bus_write(8'h18, 32'h0004);
    chk("R12 level low", 32'(irq_l), 32'h0004);
    drive_pins(16'h0004, 3);
    chk("R8 rise ignored", 32'(irq), 32'h0);
    chk("R12 low released", 32'(irq_l), 32'h0);
    drive_pins(16'h0000, 3);
    chk("R8 fall sets", 32'(irq), 32'h0004);
    bus_write(8'h38, 32'h0004);
    bus_write(8'h20, 32'h0004);

    // R9 both edges, output bit ignored; R12 pulse
    bus_write(8'h30, 32'h0010);
    bus_write(8'h18, 32'h0010);
    drive_pins(16'h0010, 2);
    chk("R12 pulse high", 32'(irq_l), 32'h0010);
    chk("R10 latency", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R12 pulse gone", 32'(irq_l), 32'h0);
    chk("R9 rise sets", 32'(irq), 32'h0010);
    bus_write(8'h38, 32'h0010);
    drive_pins(16'h0000, 3);
    chk("R9 fall sets", 32'(irq), 32'h0010);
    bus_write(8'h38, 32'h0010);
    bus_write(8'h30, 32'h0);
    bus_write(8'h10, 32'h0);

    // R10 partial clear
    drive_pins(16'h0060, 3);
    chk("R10 two pending", 32'(irq), 32'h0060);
    bus_write(8'h38, 32'h0020);
    chk("R10 partial clear", 32'(irq), 32'h0040);
    bus_write(8'h38, 32'h0);
    bus_read(8'h38, 32'h0040, "R10 zero write keeps");
    bus_write(8'h38, 32'h0040);
    drive_pins(16'h0000, 3);

    // R11 set wins over same-cycle clear
    bus_write(8'h30, 32'h0080);
    drive_pins(16'h0080, 3);
    chk("R11 setup", 32'(irq), 32'h0080);
    @(negedge clk);
    pins = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    addr = 8'h38; wdata = 32'h0080; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk("R11 set wins", 32'(irq), 32'h0080);
    bus_write(8'h38, 32'h0080);
    chk("R11 later clear", 32'(irq), 32'h0);

    // R13 status offset absent in level style
    @(negedge clk);
    addr = 8'h38; #1;
    chk("R13 level pend reads 0", rdata_lvl, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule